// File: doc/BRIEF.md
# System Reset Arbiter with Cause Flags

This block combines every reset request in the device into one system reset and records in a flag register which source raised it. The sources are a power-on detect level, a brown-out detect level that is honoured only while its enable input is high, an active-low external reset pin, a watchdog timeout, a software reset strobe, a trap-conflict lockup strobe, and a strobe for an illegal opcode or an uninitialised address pointer. The analog detectors sit outside the block and deliver clean levels.

The pin is an input only and passes through a synchroniser and a digital noise filter before it can reset anything. Internal resets never reach the pin. A watchdog timeout that arrives while the sleep input is high is a wake event: it raises no reset and sets only a wake flag. Any active source sets a held reset state. That state releases only after every source has gone quiet and a stretch counter has run out. Software reads the flags and clears any of them by writing ones. Power-on reloads the flags to a fixed pattern. Every other reset leaves the flags it does not own untouched.

Top module: `reset_hub`

## Requirements
- R1: While `por_i` is high, `sys_rst_o` is high. On the cycle after a power-on sample, `cause_o` equals 9'h003 (bit 0 power-on and bit 1 brown-out set, all other bits clear).
- R2: With `bor_en_i` high, `bor_i` raises the system reset and sets cause bit 1. With `bor_en_i` low, `bor_i` changes neither the reset nor the flags.
- R3: A low pulse on `pin_rst_n_i` of fewer than FILT_CYC clock cycles is ignored. A low pulse of FILT_CYC cycles or longer produces a system reset.
- R4: A filtered pin reset sets cause bit 2 when `sleep_i` is low at detection and cause bit 3 when `sleep_i` is high.
- R5: A `wdt_i` strobe while `sleep_i` is low raises the system reset and sets cause bit 4.
- R6: A `wdt_i` strobe while `sleep_i` is high raises no reset, sets cause bit 5 and leaves every other flag unchanged.
- R7: Strobes on `swrst_i`, `trap_i` and `illop_i` each raise the system reset and set cause bit 6, 7 and 8 respectively, whether or not `sleep_i` is high.
- R8: `sys_rst_o` rises one cycle after any request is sampled. It falls STRETCH cycles after the last cycle in which a request was sampled.
- R9: A reset other than power-on sets only its own flag. Flags set earlier stay set.
- R10: A cycle with `wr_en_i` high clears every flag whose bit in `wr_data_i` is one and leaves the others alone. A flag that is set and cleared in the same cycle ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_i | input | 1 | Power-on detect level, high while the supply is below threshold |
| bor_i | input | 1 | Brown-out detect level |
| bor_en_i | input | 1 | Enables brown-out as a reset source |
| pin_rst_n_i | input | 1 | External reset pin, active low, asynchronous, never driven by the block |
| sleep_i | input | 1 | High while the core is in sleep or idle |
| wdt_i | input | 1 | Watchdog timeout strobe |
| swrst_i | input | 1 | Software reset instruction strobe |
| trap_i | input | 1 | Trap-conflict lockup strobe |
| illop_i | input | 1 | Illegal opcode or uninitialised pointer strobe |
| wr_en_i | input | 1 | Write strobe for the flag register |
| wr_data_i | input | 9 | Write-one-to-clear mask for the flags |
| sys_rst_o | output | 1 | Stretched system reset, active high |
| cause_o | output | 9 | Reset cause flags |

## Verification
Internal strobes show up in both `sys_rst_o` and `cause_o` one cycle after they are sampled. The bench drives inputs on the falling edge and reads the outputs on the next falling edge. A pin event needs the two synchroniser stages, FILT_CYC filter samples and the edge-detect register before it counts. So the pin checks watch `sys_rst_o` across a window longer than that path plus the stretch, and read the flags only after the window. The release is checked on the exact cycles STRETCH−1 and STRETCH after the strobe edge, which shows both that the reset is held and that it drops on time.

// File: rtl/reset_hub_pkg.sv
package reset_hub_pkg;
  localparam int NFLAG       = 9;
  localparam int FL_POR      = 0;
  localparam int FL_BOR      = 1;
  localparam int FL_PIN_RUN  = 2;
  localparam int FL_PIN_SLP  = 3;
  localparam int FL_WDT_RST  = 4;
  localparam int FL_WDT_WAKE = 5;
  localparam int FL_SWR      = 6;
  localparam int FL_TRAP     = 7;
  localparam int FL_ILLOP    = 8;

  localparam logic [NFLAG-1:0] FLAGS_AFTER_POR =
    NFLAG'((1 << FL_POR) | (1 << FL_BOR));
endpackage

// File: rtl/reset_hub_pin_filter.sv
module reset_hub_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 4
) (
  input  logic clk,
  input  logic init_i,
  input  logic pin_n_i,
  output logic low_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_s;
  logic                   filt_hi;
  logic [CW-1:0]          cnt;

  always_ff @(posedge clk) begin
    if (init_i) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n_i};
  end

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (init_i) begin
      filt_hi <= 1'b1;
      cnt     <= '0;
    end else if (pin_s != filt_hi) begin
      if (cnt == CW'(FILT_CYC - 1)) begin
        filt_hi <= pin_s;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end

  assign low_o = ~filt_hi;

  // independent run counter of low samples, saturating
  logic [CW-1:0] run_lo;
  always_ff @(posedge clk) begin
    if (init_i || pin_s)              run_lo <= '0;
    else if (run_lo != CW'(FILT_CYC)) run_lo <= run_lo + 1'b1;
  end

  p_short_low_ignored_r3: assert property (@(posedge clk) disable iff (init_i)
    $fell(filt_hi) |-> (run_lo >= CW'(FILT_CYC)));
endmodule

// File: rtl/reset_hub_stretch.sv
module reset_hub_stretch #(
  parameter int STRETCH = 8
) (
  input  logic clk,
  input  logic init_i,
  input  logic req_i,
  output logic rst_o
);
  localparam int CW = (STRETCH > 1) ? $clog2(STRETCH) : 1;

  logic          rst_q;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (req_i) begin
      rst_q <= 1'b1;
      cnt   <= '0;
    end else if (rst_q) begin
      if (cnt == CW'(STRETCH - 1)) begin
        rst_q <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign rst_o = rst_q;

  p_set_on_req_r8: assert property (@(posedge clk) disable iff (init_i)
    req_i |=> rst_q);
  p_no_release_under_req_r8: assert property (@(posedge clk) disable iff (init_i)
    $fell(rst_q) |-> !$past(req_i));
endmodule

// File: rtl/reset_hub_cause.sv
module reset_hub_cause
  import reset_hub_pkg::*;
#(
  parameter int NF = NFLAG
) (
  input  logic          clk,
  input  logic          por_i,
  input  logic [NF-1:0] set_i,
  input  logic          wr_en_i,
  input  logic [NF-1:0] wr_data_i,
  output logic [NF-1:0] cause_o
);
  logic [NF-1:0] cause_q;
  logic [NF-1:0] clr;

  assign clr = wr_en_i ? wr_data_i : '0;

  always_ff @(posedge clk) begin
    if (por_i) cause_q <= NF'(FLAGS_AFTER_POR);
    else       cause_q <= (cause_q & ~clr) | set_i;
  end

  assign cause_o = cause_q;

  p_por_pattern_r1: assert property (@(posedge clk)
    por_i |=> (cause_q == NF'(FLAGS_AFTER_POR)));
  p_flags_sticky_r9: assert property (@(posedge clk) disable iff (por_i)
    !wr_en_i |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
  p_w1c_r10: assert property (@(posedge clk) disable iff (por_i)
    wr_en_i |=> ((cause_q & $past(wr_data_i & ~set_i)) == '0));
endmodule

// File: rtl/reset_hub.sv
module reset_hub
  import reset_hub_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 4,
  parameter int STRETCH     = 8
) (
  input  logic             clk,
  input  logic             por_i,
  input  logic             bor_i,
  input  logic             bor_en_i,
  input  logic             pin_rst_n_i,
  input  logic             sleep_i,
  input  logic             wdt_i,
  input  logic             swrst_i,
  input  logic             trap_i,
  input  logic             illop_i,
  input  logic             wr_en_i,
  input  logic [NFLAG-1:0] wr_data_i,
  output logic             sys_rst_o,
  output logic [NFLAG-1:0] cause_o
);
  logic             pin_low, pin_low_q, pin_entry;
  logic             bor_act, wdt_rst, wdt_wake;
  logic             any_req;
  logic [NFLAG-1:0] set_vec;

  reset_hub_pin_filter #(
    .SYNC_STAGES (SYNC_STAGES),
    .FILT_CYC    (FILT_CYC)
  ) i_pin_filter (
    .clk     (clk),
    .init_i  (por_i),
    .pin_n_i (pin_rst_n_i),
    .low_o   (pin_low)
  );

  always_ff @(posedge clk) begin
    if (por_i) pin_low_q <= 1'b0;
    else       pin_low_q <= pin_low;
  end

  assign pin_entry = pin_low & ~pin_low_q;
  assign bor_act   = bor_i & bor_en_i;
  assign wdt_rst   = wdt_i & ~sleep_i;
  assign wdt_wake  = wdt_i & sleep_i;

  always_comb begin
    set_vec              = '0;
    set_vec[FL_BOR]      = bor_act;
    set_vec[FL_PIN_RUN]  = pin_entry & ~sleep_i;
    set_vec[FL_PIN_SLP]  = pin_entry & sleep_i;
    set_vec[FL_WDT_RST]  = wdt_rst;
    set_vec[FL_WDT_WAKE] = wdt_wake;
    set_vec[FL_SWR]      = swrst_i;
    set_vec[FL_TRAP]     = trap_i;
    set_vec[FL_ILLOP]    = illop_i;
  end

  assign any_req = por_i | bor_act | pin_low | wdt_rst | swrst_i | trap_i | illop_i;

  reset_hub_stretch #(
    .STRETCH (STRETCH)
  ) i_stretch (
    .clk    (clk),
    .init_i (por_i),
    .req_i  (any_req),
    .rst_o  (sys_rst_o)
  );

  reset_hub_cause #(
    .NF (NFLAG)
  ) i_cause (
    .clk       (clk),
    .por_i     (por_i),
    .set_i     (set_vec),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cause_o   (cause_o)
  );

  p_wake_no_reset_r6: assert property (@(posedge clk) disable iff (por_i)
    (wdt_i && sleep_i && !sys_rst_o && !bor_act && !pin_low && !swrst_i && !trap_i && !illop_i)
    |=> (!sys_rst_o && cause_o[FL_WDT_WAKE]));
  p_wdt_reset_flag_r5: assert property (@(posedge clk) disable iff (por_i)
    (wdt_i && !sleep_i) |=> (sys_rst_o && cause_o[FL_WDT_RST]));
  p_bor_masked_r2: assert property (@(posedge clk) disable iff (por_i)
    (bor_i && !bor_en_i && !$past(cause_o[FL_BOR]) && !wr_en_i) |=> !cause_o[FL_BOR]);
endmodule

// File: tb/test_reset_hub.sv
module test_reset_hub;
  localparam int F  = 4;
  localparam int S  = 8;
  localparam int NF = 9;

  logic          clk = 1'b0;
  logic          por_i = 1'b1, bor_i = 1'b0, bor_en_i = 1'b1, pin_rst_n_i = 1'b1;
  logic          sleep_i = 1'b0, wdt_i = 1'b0, swrst_i = 1'b0, trap_i = 1'b0, illop_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [NF-1:0] wr_data_i = '0;
  logic          sys_rst_o;
  logic [NF-1:0] cause_o;

  int checks = 0;
  int fails  = 0;
  logic [NF-1:0] exp_cause;

  always #2.5 clk = ~clk;

  reset_hub #(.SYNC_STAGES(2), .FILT_CYC(F), .STRETCH(S)) i_reset_hub (
    .clk(clk), .por_i(por_i), .bor_i(bor_i), .bor_en_i(bor_en_i),
    .pin_rst_n_i(pin_rst_n_i), .sleep_i(sleep_i), .wdt_i(wdt_i),
    .swrst_i(swrst_i), .trap_i(trap_i), .illop_i(illop_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .sys_rst_o(sys_rst_o), .cause_o(cause_o)
  );

  // [4:0] strobes {illop,trap,swrst,wdt,bor}, [5] sleep, [6] expected reset, [15:7] flags set
  localparam logic [15:0] VEC [7] = '{
    {9'h002, 1'b1, 1'b0, 5'b00001},  // R2 brown-out enabled
    {9'h010, 1'b1, 1'b0, 5'b00010},  // R5 watchdog running
    {9'h020, 1'b0, 1'b1, 5'b00010},  // R6 watchdog in sleep
    {9'h040, 1'b1, 1'b0, 5'b00100},  // R7 software
    {9'h080, 1'b1, 1'b0, 5'b01000},  // R7 trap
    {9'h100, 1'b1, 1'b0, 5'b10000},  // R7 illegal op
    {9'h040, 1'b1, 1'b1, 5'b00100}   // R7 software while asleep
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic watch_rst(input int n, output logic seen);
    seen = 1'b0;
    repeat (n) begin
      step(1);
      if (sys_rst_o) seen = 1'b1;
    end
  endtask

  task automatic pin_pulse(input int len, input int win, output logic seen);
    pin_rst_n_i = 1'b0;
    step(len);
    pin_rst_n_i = 1'b1;
    watch_rst(win, seen);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic seen;
    step(3);
    chk("R1 reset high during power-on", 32'(sys_rst_o), 32'd1);
    por_i = 1'b0;
    step(1);
    chk("R1 flags after power-on", 32'(cause_o), 32'h003);
    step(S + 1);
    chk("R8 released after power-on", 32'(sys_rst_o), 32'd0);

    wr_en_i = 1'b1; wr_data_i = '1;
    step(1);
    wr_en_i = 1'b0; wr_data_i = '0;
    exp_cause = '0;
    chk("R10 clear all", 32'(cause_o), 32'(exp_cause));

    for (int i = 0; i < 7; i++) begin
      logic [15:0] v;
      v = VEC[i];
      sleep_i = v[5];
      bor_i = v[0]; wdt_i = v[1]; swrst_i = v[2]; trap_i = v[3]; illop_i = v[4];
      step(1);
      bor_i = 1'b0; wdt_i = 1'b0; swrst_i = 1'b0; trap_i = 1'b0; illop_i = 1'b0;
      exp_cause = exp_cause | v[15:7];
      chk($sformatf("R8 reset for vector %0d", i), 32'(sys_rst_o), 32'(v[6]));
      chk($sformatf("R9 flags for vector %0d", i), 32'(cause_o), 32'(exp_cause));
      step(S + 1);
      sleep_i = 1'b0;
    end

    // R2 disabled brown-out ignored
    bor_en_i = 1'b0; bor_i = 1'b1;
    step(3);
    chk("R2 masked brown-out reset", 32'(sys_rst_o), 32'd0);
    chk("R2 masked brown-out flags", 32'(cause_o), 32'(exp_cause));
    bor_i = 1'b0; bor_en_i = 1'b1;

    // R3 short pulse
    pin_pulse(F - 1, 20, seen);
    chk("R3 short pin pulse ignored", 32'(seen), 32'd0);
    chk("R3 short pin pulse flags", 32'(cause_o), 32'(exp_cause));

    // R3/R4 running pin reset
    pin_pulse(F, F + S + 8, seen);
    exp_cause[2] = 1'b1;
    chk("R3 full pin pulse resets", 32'(seen), 32'd1);
    chk("R4 pin reset running flag", 32'(cause_o), 32'(exp_cause));
    chk("R8 released after pin", 32'(sys_rst_o), 32'd0);

    // R4 pin reset in sleep
    sleep_i = 1'b1;
    pin_pulse(F + 2, F + S + 10, seen);
    sleep_i = 1'b0;
    exp_cause[3] = 1'b1;
    chk("R4 pin reset in sleep resets", 32'(seen), 32'd1);
    chk("R4 pin reset sleep flag", 32'(cause_o), 32'(exp_cause));

    // R8 exact stretch
    swrst_i = 1'b1;
    step(1);
    swrst_i = 1'b0;
    chk("R8 rise one cycle after request", 32'(sys_rst_o), 32'd1);
    step(S - 1);
    chk("R8 held through stretch", 32'(sys_rst_o), 32'd1);
    step(1);
    chk("R8 released after stretch", 32'(sys_rst_o), 32'd0);

    // R10 partial clear
    wr_en_i = 1'b1; wr_data_i = 9'h0C0;
    step(1);
    wr_en_i = 1'b0; wr_data_i = '0;
    exp_cause = exp_cause & ~9'h0C0;
    chk("R10 partial clear", 32'(cause_o), 32'(exp_cause));

    // R10 set wins over clear
    wr_en_i = 1'b1; wr_data_i = 9'h040; swrst_i = 1'b1;
    step(1);
    wr_en_i = 1'b0; wr_data_i = '0; swrst_i = 1'b0;
    exp_cause[6] = 1'b1;
    chk("R10 set wins over clear", 32'(cause_o), 32'(exp_cause));
    step(S + 1);

    // R1 power-on again reloads pattern
    por_i = 1'b1;
    step(2);
    chk("R1 reset on second power-on", 32'(sys_rst_o), 32'd1);
    chk("R1 flags reloaded", 32'(cause_o), 32'h003);
    por_i = 1'b0;
    step(S + 2);
    chk("R8 released after second power-on", 32'(sys_rst_o), 32'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule